// File: doc/BRIEF.md
# Panel Configuration Register Port on a Three-Wire Serial Bus

This block lets a host configure a display controller over a three-wire serial link. The link has a serial clock, an active-low select and one shared data line. At the pad the shared line is split into an input, an output and an output enable. The block holds four byte-wide registers: a free scratch register, a fixed identity byte, a first control byte whose low three bits pick the panel resolution, and a second control byte. The second control byte holds a power bit and a bit that decides who owns the settings. The block drives the resulting resolution code and standby state straight to the rest of the chip.

Every frame starts with a six-bit address, sent most significant bit first, followed by a direction bit. A write then takes one padding clock and eight data bits. A read spends the eighth clock as an undriven turnaround and then returns eight bits. When software does not own the settings, the resolution and power state come from strap pins, and reads of those fields show the strap values. The serial signals are sampled by the system clock: a rising serial edge captures input and a falling serial edge updates output.

Top module: `panel_cfg_spi`

## Requirements
- R1: A frame opens when cs_n falls. The first six rising sclk edges shift in the register address, most significant bit first. The seventh rising edge gives the direction: 1 reads, 0 writes.
- R2: On a write, the eighth clock carries a padding bit that is ignored. Clocks nine to sixteen carry the data byte, most significant bit first. The addressed register takes the byte at the sixteenth rising sclk edge.
- R3: On a read, sdio_oe stays low through the eighth clock. The falling sclk edges of clocks nine to sixteen present the read byte on sdio_out, most significant bit first, with sdio_oe high. The line is never driven during a write frame.
- R4: Address 0 is a read/write scratch register that resets to 0x00. Address 1 reads {CHIP_ID, CHIP_REV} (0x42 by default) and ignores writes. Addresses 4 to 63 read 0x00 and ignore writes.
- R5: Address 2 is control byte 1, which resets to 0x07. Its bits [2:0] hold the resolution code: 7 for 800x480, 6 for 640x480, 5 for 480x272, 4 for 480x640, 1 for 480x272 dual-scan, 0 for 400x240 dual-scan. When software owns the settings, res_code equals these bits.
- R6: Address 3 is control byte 2, which resets to 0x00. Bit 0 is the power bit (1 active, 0 standby). Bit 7 is the ownership bit. When bit 7 is 1, standby equals the inverse of bit 0.
- R7: While control byte 2 bit 7 is 0, res_code follows strap_res and standby is the inverse of strap_pwr. Reads return strap_res in bits [2:0] of address 2 and strap_pwr in bit 0 of address 3. The stored bits are kept, and they take effect once bit 7 is set.
- R8: Raising cs_n at any point ends the frame. sdio_oe falls at the next clk edge, and a write that has not reached its sixteenth clock changes no register.
- R9: A synchronous active-low rst_n returns every register to its reset value and releases the data line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial signals |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock from the host, idle high |
| cs_n | input | 1 | Active-low frame select |
| sdio_in | input | 1 | Data line as seen at the pad input |
| sdio_out | output | 1 | Value driven onto the data line |
| sdio_oe | output | 1 | Pad output enable for the data line |
| strap_res | input | 3 | Strapped resolution code |
| strap_pwr | input | 1 | Strapped power state, 1 is active |
| res_code | output | 3 | Effective resolution code |
| standby | output | 1 | Effective standby, 1 is standby |

## Verification
The assertions assume that sclk, cs_n and sdio_in are already synchronous to clk. They also assume that each sclk level lasts at least one clk period, so that every serial edge appears as exactly one detected rise or fall. The bench changes every serial input on the falling edge of clk and holds each sclk level for three clk periods. A reference model in the bench tracks the registers, the expected data-line enable and the expected read bit. It is compared with res_code, standby, sdio_oe and sdio_out after every rising clk edge, and it covers aborted frames, strap changes and a reset taken after traffic.

// File: rtl/panel_cfg_spi.sv
module panel_cfg_spi #(
  parameter int         AW         = 6,
  parameter logic [3:0] CHIP_ID    = 4'h4,
  parameter logic [3:0] CHIP_REV   = 4'h2,
  parameter logic [7:0] CTRL1_INIT = 8'h07
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk,
  input  logic       cs_n,
  input  logic       sdio_in,
  output logic       sdio_out,
  output logic       sdio_oe,
  input  logic [2:0] strap_res,
  input  logic       strap_pwr,
  output logic [2:0] res_code,
  output logic       standby
);
  localparam int DW    = 8;
  localparam int HDR   = AW + 2;
  localparam int FRAME = HDR + DW;
  localparam int CW    = $clog2(FRAME + 1);

  logic          sclk_q;
  logic [CW-1:0] cnt;
  logic [DW-1:0] sh;
  logic [AW-1:0] addr_q;
  logic          rd_q;
  logic [DW-1:0] test_q, ctrl1_q, ctrl2_q, rdata;
  logic [2:0]    bit_sel;
  logic          own, rise, fall, wr_commit;
  logic [DW-1:0] wdata;

  assign rise      = sclk & ~sclk_q & ~cs_n;
  assign fall      = ~sclk & sclk_q & ~cs_n;
  assign own       = ctrl2_q[7];
  assign wdata     = {sh[DW-2:0], sdio_in};
  assign wr_commit = rise && !rd_q && cnt == CW'(FRAME - 1);
  assign bit_sel   = 3'(CW'(FRAME - 1) - cnt);
  assign res_code  = own ? ctrl1_q[2:0] : strap_res;
  assign standby   = own ? ~ctrl2_q[0] : ~strap_pwr;

  always_comb begin
    rdata = '0;
    if (addr_q == AW'(0))      rdata = test_q;
    else if (addr_q == AW'(1)) rdata = {CHIP_ID, CHIP_REV};
    else if (addr_q == AW'(2)) rdata = own ? ctrl1_q : {ctrl1_q[7:3], strap_res};
    else if (addr_q == AW'(3)) rdata = own ? ctrl2_q : {ctrl2_q[7:1], strap_pwr};
  end

  always_ff @(posedge clk) sclk_q <= sclk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      sh       <= '0;
      addr_q   <= '0;
      rd_q     <= 1'b0;
      sdio_out <= 1'b0;
      sdio_oe  <= 1'b0;
      test_q   <= '0;
      ctrl1_q  <= CTRL1_INIT;
      ctrl2_q  <= '0;
    end else if (cs_n) begin
      cnt     <= '0;
      rd_q    <= 1'b0;
      sdio_oe <= 1'b0;
    end else begin
      if (rise && cnt < CW'(FRAME)) begin
        sh  <= wdata;
        cnt <= cnt + 1'b1;
        if (cnt == CW'(AW)) begin
          addr_q <= sh[AW-1:0];
          rd_q   <= sdio_in;
        end
      end
      if (wr_commit) begin
        if (addr_q == AW'(0))      test_q  <= wdata;
        else if (addr_q == AW'(2)) ctrl1_q <= wdata;
        else if (addr_q == AW'(3)) ctrl2_q <= wdata;
      end
      if (fall && rd_q) begin
        if (cnt >= CW'(HDR) && cnt < CW'(FRAME)) begin
          sdio_oe  <= 1'b1;
          sdio_out <= rdata[bit_sel];
        end else if (cnt == CW'(FRAME)) begin
          sdio_oe <= 1'b0;
        end
      end
    end
  end

  // R8
  cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !sdio_oe);

  // R3
  drive_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sdio_oe |-> rd_q);

  // R3
  out_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(fall)) |-> $stable(sdio_out));

  // R7
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(wr_commit) && $stable(strap_res)) |-> $stable(res_code));

  // R1
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(FRAME));
endmodule

// File: tb/sim_panel_cfg_spi.sv
`timescale 1ns/1ps
module sim_panel_cfg_spi;
  localparam int H = 3;

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b1, cs_n = 1'b1, sdio_in = 1'b0;
  logic [2:0] strap_res = 3'd5;
  logic strap_pwr = 1'b1;
  logic sdio_out, sdio_oe, standby;
  logic [2:0] res_code;

  int checks = 0, errors = 0;
  logic [7:0] m_test = 8'h00, m_c1 = 8'h07, m_c2 = 8'h00;
  logic exp_oe = 1'b0, exp_sdo = 1'b0;

  always #4 clk = ~clk;

  panel_cfg_spi u0 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdio_in(sdio_in),
    .sdio_out(sdio_out), .sdio_oe(sdio_oe), .strap_res(strap_res),
    .strap_pwr(strap_pwr), .res_code(res_code), .standby(standby));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] mread(input logic [5:0] a);
    case (a)
      6'd0: return m_test;
      6'd1: return 8'h42;
      6'd2: return m_c2[7] ? m_c1 : {m_c1[7:3], strap_res};
      6'd3: return m_c2[7] ? m_c2 : {m_c2[7:1], strap_pwr};
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    #2;
    chk("R5 R7 res_code", res_code, m_c2[7] ? m_c1[2:0] : strap_res);
    chk("R6 R7 standby", standby, m_c2[7] ? !m_c2[0] : !strap_pwr);
    chk("R3 R8 sdio_oe", sdio_oe, exp_oe);
    if (exp_oe) chk("R3 sdio_out", sdio_out, exp_sdo);
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; m_test = 8'h00; m_c1 = 8'h07; m_c2 = 8'h00; exp_oe = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(2);
  endtask

  task automatic frame(input logic [5:0] a, input bit rd, input logic [7:0] wd,
                       input int nclk, output logic [7:0] rdv);
    logic [7:0] hdr;
    logic [7:0] erd;
    hdr = {a, rd, 1'b0};
    erd = mread(a);
    rdv = 8'h00;
    @(negedge clk);
    cs_n = 1'b0;
    tick(H);
    for (int k = 1; k <= nclk; k++) begin
      sclk = 1'b0;
      sdio_in = (k <= 8) ? hdr[8-k] : (rd ? 1'b0 : wd[16-k]);
      if (rd && k >= 9) begin exp_oe = 1'b1; exp_sdo = erd[16-k]; end
      tick(H);
      sclk = 1'b1;
      if (!rd && k == 16) begin
        if (a == 6'd0) m_test = wd;
        else if (a == 6'd2) m_c1 = wd;
        else if (a == 6'd3) m_c2 = wd;
      end
      tick(H);
      if (rd && k >= 9) rdv[16-k] = sdio_out;
    end
    cs_n = 1'b1; exp_oe = 1'b0;
    tick(H);
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    logic [7:0] dummy;
    frame(a, 1'b0, d, 16, dummy);
  endtask

  task automatic rd_chk(input string tag, input logic [5:0] a, input logic [7:0] exp);
    logic [7:0] v;
    frame(a, 1'b1, 8'h00, 16, v);
    chk(tag, v, exp);
  endtask

  initial begin
    logic [7:0] v;
    do_reset();
    // R9 reset state seen through reads
    rd_chk("R9 R4 test reset", 6'd0, 8'h00);
    rd_chk("R4 identity", 6'd1, 8'h42);
    rd_chk("R7 ctrl1 strap field", 6'd2, 8'h05);
    rd_chk("R7 ctrl2 strap field", 6'd3, 8'h01);
    // R1 R2 scratch write and readback
    wr(6'd0, 8'h55);
    rd_chk("R1 R2 test 0x55", 6'd0, 8'h55);
    wr(6'd0, 8'hA3);
    rd_chk("R2 test 0xA3", 6'd0, 8'hA3);
    // R4 read-only and unmapped
    wr(6'd1, 8'h00);
    rd_chk("R4 identity after write", 6'd1, 8'h42);
    wr(6'd42, 8'hFF);
    rd_chk("R4 unmapped reads zero", 6'd42, 8'h00);
    rd_chk("R4 test untouched by unmapped write", 6'd0, 8'hA3);
    // R7 stored ctrl1 kept while straps own the outputs
    wr(6'd2, 8'hF6);
    rd_chk("R7 ctrl1 read with straps", 6'd2, 8'hF5);
    strap_res = 3'd4; strap_pwr = 1'b0;
    tick(4);
    chk("R7 res follows strap", res_code, 3'd4);
    chk("R7 standby follows strap", standby, 1);
    // R5 R6 software ownership
    wr(6'd3, 8'h81);
    chk("R5 res from ctrl1", res_code, 3'd6);
    chk("R6 active", standby, 0);
    rd_chk("R5 ctrl1 full", 6'd2, 8'hF6);
    rd_chk("R6 ctrl2 full", 6'd3, 8'h81);
    wr(6'd3, 8'h80);
    chk("R6 standby set", standby, 1);
    strap_res = 3'd1; strap_pwr = 1'b1;
    tick(4);
    chk("R7 straps ignored when owned", res_code, 3'd6);
    wr(6'd2, 8'h00);
    chk("R5 dual-scan code 0", res_code, 3'd0);
    // R8 aborted write and aborted read
    frame(6'd0, 1'b0, 8'h11, 12, v);
    rd_chk("R8 partial write discarded", 6'd0, 8'hA3);
    frame(6'd0, 1'b0, 8'h22, 15, v);
    rd_chk("R8 write cut at clock 15", 6'd0, 8'hA3);
    frame(6'd1, 1'b1, 8'h00, 11, v);
    chk("R8 partial read bits", v[7:5], 3'b010);
    // R9 reset after traffic
    do_reset();
    rd_chk("R9 ctrl1 after reset", 6'd2, 8'h01);
    rd_chk("R9 ctrl2 after reset", 6'd3, 8'h01);
    rd_chk("R9 test after reset", 6'd0, 8'h00);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R9 watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule